// File: doc/BRIEF.md
# Write-Only Ring Station

This block is one station of a one-way ring that moves write transfers between tiles. Each transfer is a destination address paired with one data word. A chain of these stations lets any core store into the local memory of any other tile. Nothing is ever read across the ring, so the ring has no return path.

Each station holds a single pipeline register, one multiplexer and one address comparator. A word arrives from the upstream neighbour. If its address falls inside this tile's window, the station takes it off the ring and presents it at once on the local memory write port. If the address is outside the window, the station latches the word and passes it downstream one clock later. The local core can put one word per cycle onto the ring, but only while no word in transit needs the slot. The same core also reaches its own memory directly through a port that the station arbitrates. A delivery from the ring always takes that port ahead of the core.

The tile window is aligned and has a power-of-two size. It is given by the `BASE_ADDR` and `SIZE_LOG2` parameters, and only the address bits above the window offset are compared.

Top module: `ring_stop`

## Requirements
- R1: After reset is released, `ring_out_vld_o` is low until a word is forwarded or injected.
- R2: A valid incoming word that hits the window drives `mem_en_o=1`, `mem_we_o=1`, `mem_addr_o` = its low `SIZE_LOG2` address bits and `mem_wdata_o` = its data, all in the same cycle. It does not reach `ring_out_vld_o` on the next cycle unless an injection fills the slot.
- R3: A valid incoming word that misses the window appears unchanged on the `ring_out_*` outputs on the next clock cycle.
- R4: A word hits when address bits [ADDR_W-1:SIZE_LOG2] equal the same bits of `BASE_ADDR`. The low `SIZE_LOG2` bits play no part in the decision.
- R5: `inj_rdy_o` is high exactly when no incoming word needs forwarding. This means `ring_in_vld_i` is low, or the incoming word hits. An injection accepted with `inj_vld_i & inj_rdy_o` appears on `ring_out_*` on the next cycle.
- R6: When `inj_rdy_o` is low, the forwarded ring word occupies the output register and the offered injection does not appear on the ring.
- R7: A ring delivery wins the memory port. `cpu_gnt_o` is low in that cycle, even if `cpu_req_i` is high.
- R8: Without a ring delivery, a core request passes through with `cpu_gnt_o=1`, `mem_we_o=cpu_we_i`, `mem_addr_o=cpu_addr_i` and `mem_wdata_o=cpu_wdata_i`. With neither a delivery nor a request, `mem_en_o=0`.
- R9: If no word is forwarded and none is injected in a cycle, `ring_out_vld_o` is low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ring_in_vld_i | input | 1 | Upstream slot holds a word |
| ring_in_addr_i | input | ADDR_W | Upstream word address |
| ring_in_data_i | input | DATA_W | Upstream word data |
| ring_out_vld_o | output | 1 | Station register holds a word |
| ring_out_addr_o | output | ADDR_W | Downstream word address |
| ring_out_data_o | output | DATA_W | Downstream word data |
| inj_vld_i | input | 1 | Local core offers a remote write |
| inj_addr_i | input | ADDR_W | Injected address |
| inj_data_i | input | DATA_W | Injected data |
| inj_rdy_o | output | 1 | Slot free, injection taken this cycle |
| cpu_req_i | input | 1 | Local core memory access request |
| cpu_we_i | input | 1 | Local access is a write |
| cpu_addr_i | input | SIZE_LOG2 | Local access offset |
| cpu_wdata_i | input | DATA_W | Local write data |
| cpu_gnt_o | output | 1 | Local access granted this cycle |
| mem_en_o | output | 1 | Memory port enable |
| mem_we_o | output | 1 | Memory port write enable |
| mem_addr_o | output | SIZE_LOG2 | Memory port offset |
| mem_wdata_o | output | DATA_W | Memory port write data |

## Verification
Two kinds of collision can happen in the same cycle. The first is between a ring delivery and a local core access to the memory port. The second is between a word in transit and a local injection, both needing the single slot. The bench sweeps every address of a 256-byte space on the ring input, and in each cycle combines it with both settings of the injection offer and of the core request. The hit/miss result worked out in the bench decides who should win. The bench then checks the memory port and the core grant in the same cycle, and checks the slot contents one cycle later.

// File: rtl/ring_pkg.sv
package ring_pkg;
  typedef enum logic [1:0] {
    MEM_IDLE = 2'd0,
    MEM_RING = 2'd1,
    MEM_CPU  = 2'd2
  } mem_src_e;
endpackage

// File: rtl/ring_addr_match.sv
module ring_addr_match #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned SIZE_LOG2 = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam int unsigned TAG_W = ADDR_W - SIZE_LOG2;

  generate
    if (TAG_W == 0) begin : g_whole_space
      assign hit_o = 1'b1;
    end else begin : g_tag_cmp
      localparam logic [TAG_W-1:0] BASE_TAG = BASE_ADDR[ADDR_W-1:SIZE_LOG2];
      assign hit_o = (addr_i[ADDR_W-1:SIZE_LOG2] == BASE_TAG);
    end
  endgenerate
endmodule

// File: rtl/ring_slot_reg.sv
module ring_slot_reg #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fwd_vld_i,
  input  logic [ADDR_W-1:0] fwd_addr_i,
  input  logic [DATA_W-1:0] fwd_data_i,
  input  logic              inj_vld_i,
  input  logic [ADDR_W-1:0] inj_addr_i,
  input  logic [DATA_W-1:0] inj_data_i,
  output logic              inj_rdy_o,
  output logic              q_vld_o,
  output logic [ADDR_W-1:0] q_addr_o,
  output logic [DATA_W-1:0] q_data_o
);
  logic              d_vld;
  logic [ADDR_W-1:0] d_addr;
  logic [DATA_W-1:0] d_data;

  // transit traffic owns the slot
  assign inj_rdy_o = ~fwd_vld_i;

  always_comb begin
    d_vld  = fwd_vld_i | inj_vld_i;
    d_addr = fwd_vld_i ? fwd_addr_i : inj_addr_i;
    d_data = fwd_vld_i ? fwd_data_i : inj_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_vld_o  <= 1'b0;
      q_addr_o <= '0;
      q_data_o <= '0;
    end else begin
      q_vld_o <= d_vld;
      if (d_vld) begin
        q_addr_o <= d_addr;
        q_data_o <= d_data;
      end
    end
  end

  AST_FWD_TAKES_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_vld_i |=> (q_vld_o && q_addr_o == $past(fwd_addr_i) && q_data_o == $past(fwd_data_i))); // R3
  AST_EMPTY_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fwd_vld_i && !inj_vld_i) |=> !q_vld_o); // R9
endmodule

// File: rtl/ring_mem_arb.sv
module ring_mem_arb
  import ring_pkg::*;
#(
  parameter int unsigned OFS_W  = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ring_wr_i,
  input  logic [OFS_W-1:0]  ring_ofs_i,
  input  logic [DATA_W-1:0] ring_data_i,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [OFS_W-1:0]  cpu_ofs_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_gnt_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [OFS_W-1:0]  mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  mem_src_e src;

  always_comb begin
    if (ring_wr_i)      src = MEM_RING;
    else if (cpu_req_i) src = MEM_CPU;
    else                src = MEM_IDLE;
  end

  always_comb begin
    cpu_gnt_o   = 1'b0;
    mem_en_o    = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (src)
      MEM_RING: begin
        mem_en_o    = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = ring_ofs_i;
        mem_wdata_o = ring_data_i;
      end
      MEM_CPU: begin
        cpu_gnt_o   = 1'b1;
        mem_en_o    = 1'b1;
        mem_we_o    = cpu_we_i;
        mem_addr_o  = cpu_ofs_i;
        mem_wdata_o = cpu_wdata_i;
      end
      default: ;
    endcase
  end

  AST_RING_BEATS_CPU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ring_wr_i |-> (!cpu_gnt_o && mem_we_o && mem_addr_o == ring_ofs_i)); // R7
  AST_IDLE_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ring_wr_i && !cpu_req_i) |-> !mem_en_o); // R8
endmodule

// File: rtl/ring_stop.sv
module ring_stop #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned SIZE_LOG2 = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0400
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ring_in_vld_i,
  input  logic [ADDR_W-1:0]    ring_in_addr_i,
  input  logic [DATA_W-1:0]    ring_in_data_i,
  output logic                 ring_out_vld_o,
  output logic [ADDR_W-1:0]    ring_out_addr_o,
  output logic [DATA_W-1:0]    ring_out_data_o,
  input  logic                 inj_vld_i,
  input  logic [ADDR_W-1:0]    inj_addr_i,
  input  logic [DATA_W-1:0]    inj_data_i,
  output logic                 inj_rdy_o,
  input  logic                 cpu_req_i,
  input  logic                 cpu_we_i,
  input  logic [SIZE_LOG2-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0]    cpu_wdata_i,
  output logic                 cpu_gnt_o,
  output logic                 mem_en_o,
  output logic                 mem_we_o,
  output logic [SIZE_LOG2-1:0] mem_addr_o,
  output logic [DATA_W-1:0]    mem_wdata_o
);
  localparam int unsigned OFS_W = SIZE_LOG2;

  logic addr_hit;
  logic deliver;
  logic fwd_vld;

  ring_addr_match #(
    .ADDR_W   (ADDR_W),
    .SIZE_LOG2(SIZE_LOG2),
    .BASE_ADDR(BASE_ADDR)
  ) u_match (
    .addr_i(ring_in_addr_i),
    .hit_o (addr_hit)
  );

  assign deliver = ring_in_vld_i &  addr_hit;
  assign fwd_vld = ring_in_vld_i & ~addr_hit;

  ring_slot_reg #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_slot (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fwd_vld_i (fwd_vld),
    .fwd_addr_i(ring_in_addr_i),
    .fwd_data_i(ring_in_data_i),
    .inj_vld_i (inj_vld_i),
    .inj_addr_i(inj_addr_i),
    .inj_data_i(inj_data_i),
    .inj_rdy_o (inj_rdy_o),
    .q_vld_o   (ring_out_vld_o),
    .q_addr_o  (ring_out_addr_o),
    .q_data_o  (ring_out_data_o)
  );

  ring_mem_arb #(
    .OFS_W (OFS_W),
    .DATA_W(DATA_W)
  ) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ring_wr_i  (deliver),
    .ring_ofs_i (ring_in_addr_i[OFS_W-1:0]),
    .ring_data_i(ring_in_data_i),
    .cpu_req_i  (cpu_req_i),
    .cpu_we_i   (cpu_we_i),
    .cpu_ofs_i  (cpu_addr_i),
    .cpu_wdata_i(cpu_wdata_i),
    .cpu_gnt_o  (cpu_gnt_o),
    .mem_en_o   (mem_en_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o)
  );

  AST_HIT_LEAVES_RING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ring_in_vld_i && addr_hit && !inj_vld_i) |=> !ring_out_vld_o); // R2
  AST_HIT_TO_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ring_in_vld_i && addr_hit) |-> (mem_en_o && mem_wdata_o == ring_in_data_i)); // R2
  AST_INJ_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ring_in_vld_i && !addr_hit) |-> !inj_rdy_o); // R6
  AST_INJ_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inj_vld_i && inj_rdy_o) |=> (ring_out_vld_o && ring_out_addr_o == $past(inj_addr_i)
                                  && ring_out_data_o == $past(inj_data_i))); // R5
endmodule

// File: tb/ring_stop_bench.sv
module ring_stop_bench;
  localparam int unsigned AW = 8;
  localparam int unsigned DW = 16;
  localparam int unsigned SL = 4;
  localparam logic [AW-1:0] BASE = 8'h30;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rin_vld = 1'b0;
  logic [AW-1:0] rin_addr = '0;
  logic [DW-1:0] rin_data = '0;
  logic          rout_vld;
  logic [AW-1:0] rout_addr;
  logic [DW-1:0] rout_data;
  logic          inj_vld = 1'b0;
  logic [AW-1:0] inj_addr = '0;
  logic [DW-1:0] inj_data = '0;
  logic          inj_rdy;
  logic          cpu_req = 1'b0;
  logic          cpu_we = 1'b0;
  logic [SL-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_gnt;
  logic          mem_en;
  logic          mem_we;
  logic [SL-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ring_stop #(
    .ADDR_W(AW), .DATA_W(DW), .SIZE_LOG2(SL), .BASE_ADDR(BASE)
  ) u_ring_stop (
    .clk_i(clk), .rst_ni(rst_n),
    .ring_in_vld_i(rin_vld), .ring_in_addr_i(rin_addr), .ring_in_data_i(rin_data),
    .ring_out_vld_o(rout_vld), .ring_out_addr_o(rout_addr), .ring_out_data_o(rout_data),
    .inj_vld_i(inj_vld), .inj_addr_i(inj_addr), .inj_data_i(inj_data), .inj_rdy_o(inj_rdy),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_gnt_o(cpu_gnt),
    .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : stim
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_vld after reset", int'(rout_vld), 0);

    // full sweep: ring word present, injection and core request combined
    for (int a = 0; a < 256; a++) begin
      for (int m = 0; m < 4; m++) begin
        bit hit;
        bit v;
        bit c;
        logic [AW-1:0] ia;
        logic [DW-1:0] idat;
        logic [DW-1:0] rdat;
        v = m[0];
        c = m[1];
        hit = ((a >> SL) == (int'(BASE) >> SL));   // R4
        rdat = DW'(a * 257 + 1);
        ia = AW'(a ^ 8'h5a);
        idat = DW'(a * 3 + 7 + m);
        rin_vld = 1'b1; rin_addr = AW'(a); rin_data = rdat;
        inj_vld = v; inj_addr = ia; inj_data = idat;
        cpu_req = c; cpu_we = a[0]; cpu_addr = SL'(a + 5); cpu_wdata = DW'(a + 100);
        #2;
        chk("R5 inj_rdy", int'(inj_rdy), int'(hit));
        chk("R7 cpu_gnt", int'(cpu_gnt), int'(c && !hit));
        chk("R8 mem_en", int'(mem_en), int'(hit || c));
        if (hit) begin
          chk("R2 mem_we", int'(mem_we), 1);
          chk("R2 mem_addr", int'(mem_addr), a % 16);
          chk("R2 mem_wdata", int'(mem_wdata), int'(rdat));
        end else if (c) begin
          chk("R8 mem_we", int'(mem_we), a % 2);
          chk("R8 mem_addr", int'(mem_addr), (a + 5) % 16);
          chk("R8 mem_wdata", int'(mem_wdata), (a + 100) % 65536);
        end
        @(negedge clk);
        if (!hit) begin
          chk("R3 fwd vld", int'(rout_vld), 1);
          chk("R3 fwd addr", int'(rout_addr), a);
          chk("R6 fwd data", int'(rout_data), int'(rdat));
        end else if (v) begin
          chk("R5 inj vld", int'(rout_vld), 1);
          chk("R5 inj addr", int'(rout_addr), int'(ia));
          chk("R5 inj data", int'(rout_data), int'(idat));
        end else begin
          chk("R2 not forwarded", int'(rout_vld), 0);
        end
      end
    end

    // empty ring: injection free, core owns the port
    for (int k = 0; k < 64; k++) begin
      rin_vld = 1'b0; rin_addr = AW'(BASE + k % 16);
      inj_vld = k[0]; inj_addr = AW'(k * 7); inj_data = DW'(k * 11 + 2);
      cpu_req = k[1]; cpu_we = k[2]; cpu_addr = SL'(k); cpu_wdata = DW'(k + 9);
      #2;
      chk("R5 rdy idle ring", int'(inj_rdy), 1);
      chk("R8 gnt", int'(cpu_gnt), int'(k[1]));
      chk("R8 en", int'(mem_en), int'(k[1]));
      if (k[1]) begin
        chk("R8 we", int'(mem_we), int'(k[2]));
        chk("R8 addr", int'(mem_addr), k % 16);
      end
      @(negedge clk);
      chk("R9 out vld", int'(rout_vld), int'(k[0]));
      if (k[0]) chk("R5 addr", int'(rout_addr), (k * 7) % 256);
    end

    rin_vld = 1'b0; inj_vld = 1'b0; cpu_req = 1'b0;
    @(negedge clk);
    chk("R9 idle", int'(rout_vld), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule